// File: doc/BRIEF.md
# FIFO-fed PWM generator core

This block is the counting core of a pulse-width modulator whose duty values come from an external sample FIFO. A 12-bit prescaler divides the core clock by (divider + 1). Each prescaled tick advances a 16-bit up-counter. The counter runs from zero up to the programmed period value plus one and then rolls back to zero, so one output cycle lasts (period + 2) ticks. The sample taken from the FIFO is the compare value. The output pin switches at rollover and at compare, in one of two polarities, or it is held low. A sample can be reused for 1, 2, 4 or 8 output cycles before the next one is popped. When the FIFO is empty at that point, the current sample stays in use.

The surrounding bus logic and the FIFO storage sit outside the block. Configuration arrives through simple write strobes. These cover control (enable, output mode, sample repeat, prescale divider, software reset), the low-power run bits, the period and the interrupt enables. The FIFO is read as first-word-fall-through: the block raises `fifo_pop` in the same cycle in which it takes `fifo_data`. Rollover and compare events latch sticky flags, which are cleared by writing ones. The interrupt line combines the flags with their enables. Four low-power request inputs can pause the prescaler and the counter unless the matching run bit is set. A software reset returns every register to its reset value, except those run bits.

Top module: `fifo_pwm_core`

## Requirements
- R1: With prescale divider D, the counter advances once every D+1 clock cycles while running.
- R2: With period P, the counter takes the values 0 through P+1 and then returns to 0. Each return to 0 sets the rollover flag (flag bit 0). One output cycle therefore spans P+2 ticks.
- R3: A period of 0xFFFF behaves exactly like 0xFFFE. The counter reaches 0xFFFF and rolls over to 0 on the next tick, setting the rollover flag.
- R4: Output mode 0 drives the pin high at rollover and low when the count equals the sample, so the pin is high while count < sample. Mode 1 is the inverse. Modes 2 and 3 hold the pin low.
- R5: On the write that sets enable, the count starts at 0 and the pin takes its start level (high in mode 0, low in mode 1). The first sample is popped in the same cycle. While disabled, the pin is low and the count is 0.
- R6: A repeat code k (0 to 3) uses each sample for 2^k output cycles. The next sample is popped at the rollover that ends the last of those cycles.
- R7: If the FIFO is empty when a new sample is due, the current sample stays in use and no pop is issued.
- R8: A compare event sets the compare flag (flag bit 1). Writing a one to a flag bit clears that flag. The interrupt output is high exactly when some flag is set together with its enable, and enable bit i belongs to flag bit i.
- R9: A software reset write is visible on `swr_busy` for one cycle and then clears itself. It returns enable, mode, repeat, divider, period, interrupt enables, flags, sample and count to zero, but keeps the low-power run bits.
- R10: Low-power request bit i (0 stop, 1 doze, 2 wait, 3 debug) pauses the prescaler and the counter while run bit i is clear. When run bit i is set, counting continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_swr | input | 1 | With ctl_wr: software reset instead of a control update |
| ctl_en | input | 1 | Enable value written by ctl_wr |
| ctl_mode | input | 2 | Output mode written by ctl_wr |
| ctl_rep | input | 2 | Sample repeat code written by ctl_wr |
| ctl_pre | input | 12 | Prescale divider written by ctl_wr |
| lp_wr | input | 1 | Low-power run bits write strobe |
| lp_wdata | input | 4 | Run bits (stop, doze, wait, debug) |
| lp_req | input | 4 | Low-power mode requests, same bit order |
| per_wr | input | 1 | Period write strobe |
| per_wdata | input | 16 | Period value |
| ien_wr | input | 1 | Interrupt enable write strobe |
| ien_wdata | input | 2 | Enables: bit 0 rollover, bit 1 compare |
| flag_clr | input | 2 | Write-one-to-clear for the flags |
| fifo_empty | input | 1 | Sample FIFO holds no data |
| fifo_data | input | 16 | Head sample of the FIFO |
| fifo_pop | output | 1 | Head sample taken this cycle |
| pwm_out | output | 1 | Modulated output pin |
| cnt_value | output | 16 | Current count |
| sample_value | output | 16 | Sample in use |
| flag_rov | output | 1 | Rollover flag |
| flag_cmp | output | 1 | Compare flag |
| irq | output | 1 | Interrupt request |
| swr_busy | output | 1 | Software reset bit, self-clearing |

## Verification
Every result is registered, so a write or a tick shows at the ports one clock edge after the strobe or prescaler terminal count. The count reads n exactly n ticks after the enable edge. Pin edges, flag sets and sample changes appear on the edge of the tick that produces them. The software reset shows on `swr_busy` one edge after the write and is gone one edge later. The bench drives each strobe at a falling edge and reads the outputs at later falling edges. Its expected values are indexed by the number of edges since the enable write, so every comparison lands in the cycle computed from this latency.

// File: rtl/pwm_core_pkg.sv
package pwm_core_pkg;

    typedef enum logic [1:0] {
        OUT_SET_ROLL = 2'd0,
        OUT_CLR_ROLL = 2'd1,
        OUT_OFF      = 2'd2,
        OUT_OFF_ALT  = 2'd3
    } out_mode_e;

    localparam int FLAG_ROV = 0;
    localparam int FLAG_CMP = 1;
    localparam int LP_MODES = 4;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [PRE_W-1:0] div,
    output logic             tick
);
    logic [PRE_W-1:0] pre_d, pre_q;

    always_comb begin
        tick  = run && (pre_q >= div);
        pre_d = pre_q;
        if (clr || tick) begin
            pre_d = '0;
        end else if (run) begin
            pre_d = pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nx,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] PER_TOP   = '1;
    localparam logic [CNT_W-1:0] PER_CLAMP = PER_TOP - 1'b1;

    logic [CNT_W-1:0] per_eff;
    logic [CNT_W:0]   last_cnt;
    logic             at_end;

    always_comb begin
        per_eff  = (period == PER_TOP) ? PER_CLAMP : period;
        last_cnt = {1'b0, per_eff} + 1'b1;
        at_end   = ({1'b0, cnt_q} >= last_cnt);
        wrap     = tick && at_end;
        cnt_nx   = cnt_q;
        if (clr)       cnt_nx = '0;
        else if (tick) cnt_nx = at_end ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nx;
    end
endmodule

// File: rtl/pwm_sample_sel.sv
module pwm_sample_sel #(
    parameter int DAT_W = 16,
    parameter int REP_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             swr,
    input  logic             start,
    input  logic             wrap,
    input  logic [REP_W-1:0] rep_sel,
    input  logic             fifo_empty,
    input  logic [DAT_W-1:0] fifo_data,
    output logic             fifo_pop,
    output logic [DAT_W-1:0] sample_q,
    output logic [DAT_W-1:0] sample_nx
);
    localparam int RC_W = (1 << REP_W) - 1;

    typedef struct packed {
        logic [RC_W-1:0]  rep;
        logic [DAT_W-1:0] smp;
    } sel_t;

    sel_t            s_d, s_q;
    logic [RC_W-1:0] rep_last;
    logic            last_use;
    logic            need_new;

    always_comb begin
        rep_last  = RC_W'((32'd1 << rep_sel) - 32'd1);
        last_use  = (s_q.rep >= rep_last);
        need_new  = start || (wrap && last_use);
        fifo_pop  = need_new && !fifo_empty && !swr;
        s_d       = s_q;
        if (swr) begin
            s_d = '0;
        end else begin
            if (start)     s_d.rep = '0;
            else if (wrap) s_d.rep = last_use ? '0 : s_q.rep + 1'b1;
            if (fifo_pop)  s_d.smp = fifo_data;
        end
        sample_nx = s_d.smp;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sample_q = s_q.smp;
endmodule

// File: rtl/fifo_pwm_core.sv
module fifo_pwm_core
    import pwm_core_pkg::*;
#(
    parameter int PRE_W = 12,
    parameter int CNT_W = 16,
    parameter int REP_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_swr,
    input  logic             ctl_en,
    input  logic [1:0]       ctl_mode,
    input  logic [REP_W-1:0] ctl_rep,
    input  logic [PRE_W-1:0] ctl_pre,
    input  logic             lp_wr,
    input  logic [3:0]       lp_wdata,
    input  logic [3:0]       lp_req,
    input  logic             per_wr,
    input  logic [CNT_W-1:0] per_wdata,
    input  logic             ien_wr,
    input  logic [1:0]       ien_wdata,
    input  logic [1:0]       flag_clr,
    input  logic             fifo_empty,
    input  logic [CNT_W-1:0] fifo_data,
    output logic             fifo_pop,
    output logic             pwm_out,
    output logic [CNT_W-1:0] cnt_value,
    output logic [CNT_W-1:0] sample_value,
    output logic             flag_rov,
    output logic             flag_cmp,
    output logic             irq,
    output logic             swr_busy
);
    typedef struct packed {
        logic             en;
        logic [1:0]       mode;
        logic [REP_W-1:0] rep;
        logic [PRE_W-1:0] pre;
        logic [3:0]       lp_run;
        logic [CNT_W-1:0] per;
        logic [1:0]       ien;
        logic             swr;
    } ctl_t;

    typedef struct packed {
        logic [1:0] flg;
        logic       out;
    } pin_t;

    ctl_t ctl_d, ctl_q;
    pin_t pin_d, pin_q;

    logic             swr_evt, start, paused, run, clr;
    logic             tick, wrap, cmp_evt;
    logic             start_lvl, cmp_lvl, off_mode;
    logic [CNT_W-1:0] cnt_nx, sample_nx;
    logic             en_q;
    logic [1:0]       mode_q;

    // register updates from the write strobes
    always_comb begin
        swr_evt   = ctl_wr && ctl_swr;
        ctl_d     = ctl_q;
        ctl_d.swr = 1'b0;
        if (swr_evt) begin
            ctl_d        = '0;
            ctl_d.swr    = 1'b1;
            ctl_d.lp_run = ctl_q.lp_run;
        end else begin
            if (ctl_wr) begin
                ctl_d.en   = ctl_en;
                ctl_d.mode = ctl_mode;
                ctl_d.rep  = ctl_rep;
                ctl_d.pre  = ctl_pre;
            end
            if (lp_wr)  ctl_d.lp_run = lp_wdata;
            if (per_wr) ctl_d.per    = per_wdata;
            if (ien_wr) ctl_d.ien    = ien_wdata;
        end
        start  = ctl_d.en && !ctl_q.en;
        paused = |(lp_req & ~ctl_q.lp_run);
        run    = ctl_q.en && !paused;
        clr    = !ctl_q.en;
    end

    pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .run  (run),
        .div  (ctl_q.pre),
        .tick (tick)
    );

    pwm_period_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .tick  (tick),
        .period(ctl_q.per),
        .cnt_q (cnt_value),
        .cnt_nx(cnt_nx),
        .wrap  (wrap)
    );

    pwm_sample_sel #(.DAT_W(CNT_W), .REP_W(REP_W)) u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .swr       (swr_evt),
        .start     (start),
        .wrap      (wrap),
        .rep_sel   (ctl_q.rep),
        .fifo_empty(fifo_empty),
        .fifo_data (fifo_data),
        .fifo_pop  (fifo_pop),
        .sample_q  (sample_value),
        .sample_nx (sample_nx)
    );

    // events, sticky flags and the output pin
    always_comb begin
        cmp_evt   = tick && (cnt_nx == sample_nx);
        start_lvl = (ctl_d.mode == OUT_SET_ROLL);
        cmp_lvl   = (ctl_d.mode == OUT_CLR_ROLL);
        off_mode  = ctl_d.mode[1];
        pin_d     = pin_q;
        if (swr_evt) begin
            pin_d.flg = '0;
        end else begin
            pin_d.flg = pin_q.flg & ~flag_clr;
            if (wrap)    pin_d.flg[FLAG_ROV] = 1'b1;
            if (cmp_evt) pin_d.flg[FLAG_CMP] = 1'b1;
        end
        if (!ctl_d.en || off_mode) begin
            pin_d.out = 1'b0;
        end else if (start) begin
            pin_d.out = (sample_nx == '0) ? cmp_lvl : start_lvl;
        end else if (cmp_evt) begin
            pin_d.out = cmp_lvl;
        end else if (wrap) begin
            pin_d.out = start_lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            pin_q <= '0;
        end else begin
            ctl_q <= ctl_d;
            pin_q <= pin_d;
        end
    end

    assign pwm_out  = pin_q.out;
    assign flag_rov = pin_q.flg[FLAG_ROV];
    assign flag_cmp = pin_q.flg[FLAG_CMP];
    assign irq      = |(pin_q.flg & ctl_q.ien);
    assign swr_busy = ctl_q.swr;
    assign en_q     = ctl_q.en;
    assign mode_q   = ctl_q.mode;
endmodule

// File: rtl/fifo_pwm_core_chk.sv
module fifo_pwm_core_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_q,
    input logic             run,
    input logic [1:0]       mode_q,
    input logic             swr_busy,
    input logic             fifo_pop,
    input logic             fifo_empty,
    input logic             pwm_out,
    input logic [CNT_W-1:0] cnt_value,
    input logic             flag_rov
);
    assert_rov_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_rov) |-> (cnt_value == '0));

    assert_off_mode_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && mode_q[1]) |-> !pwm_out);

    assert_disabled_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !pwm_out);

    assert_no_pop_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    assert_swr_self_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        swr_busy |=> !swr_busy);

    assert_pause_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !run) |=> $stable(cnt_value));
endmodule

bind fifo_pwm_core fifo_pwm_core_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_q      (en_q),
    .run       (run),
    .mode_q    (mode_q),
    .swr_busy  (swr_busy),
    .fifo_pop  (fifo_pop),
    .fifo_empty(fifo_empty),
    .pwm_out   (pwm_out),
    .cnt_value (cnt_value),
    .flag_rov  (flag_rov)
);

// File: tb/fifo_pwm_core_bench.sv
`timescale 1ns/1ps
module fifo_pwm_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0, ctl_swr = 1'b0, ctl_en = 1'b0;
    logic [1:0]  ctl_mode = '0;
    logic [1:0]  ctl_rep = '0;
    logic [11:0] ctl_pre = '0;
    logic        lp_wr = 1'b0;
    logic [3:0]  lp_wdata = '0, lp_req = '0;
    logic        per_wr = 1'b0;
    logic [15:0] per_wdata = '0;
    logic        ien_wr = 1'b0;
    logic [1:0]  ien_wdata = '0, flag_clr = '0;
    logic        fifo_empty;
    logic [15:0] fifo_data;
    logic        fifo_pop, pwm_out, flag_rov, flag_cmp, irq, swr_busy;
    logic [15:0] cnt_value, sample_value;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] fq [8];
    logic [2:0]  rd_p = '0;
    logic [2:0]  wr_p = '0;

    always #2 clk = ~clk;

    assign fifo_empty = (rd_p == wr_p);
    assign fifo_data  = fq[rd_p];
    always @(posedge clk) if (fifo_pop) rd_p <= rd_p + 3'd1;

    fifo_pwm_core u_fifo_pwm_core (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_swr(ctl_swr), .ctl_en(ctl_en), .ctl_mode(ctl_mode),
        .ctl_rep(ctl_rep), .ctl_pre(ctl_pre),
        .lp_wr(lp_wr), .lp_wdata(lp_wdata), .lp_req(lp_req),
        .per_wr(per_wr), .per_wdata(per_wdata),
        .ien_wr(ien_wr), .ien_wdata(ien_wdata), .flag_clr(flag_clr),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
        .pwm_out(pwm_out), .cnt_value(cnt_value), .sample_value(sample_value),
        .flag_rov(flag_rov), .flag_cmp(flag_cmp), .irq(irq), .swr_busy(swr_busy)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [15:0] v);
        fq[wr_p] = v;
        wr_p     = wr_p + 3'd1;
    endtask

    task automatic wr_ctl(input bit en, input logic [1:0] mode, input logic [1:0] rep,
                          input logic [11:0] pre);
        ctl_wr = 1'b1; ctl_en = en; ctl_mode = mode; ctl_rep = rep; ctl_pre = pre;
        step(1);
        ctl_wr = 1'b0;
    endtask

    task automatic wr_per(input logic [15:0] p);
        per_wr = 1'b1; per_wdata = p; step(1); per_wr = 1'b0;
    endtask

    task automatic wr_ien(input logic [1:0] v);
        ien_wr = 1'b1; ien_wdata = v; step(1); ien_wr = 1'b0;
    endtask

    task automatic wr_lp(input logic [3:0] v);
        lp_wr = 1'b1; lp_wdata = v; step(1); lp_wr = 1'b0;
    endtask

    task automatic clr_flags(input logic [1:0] v);
        flag_clr = v; step(1); flag_clr = 2'b00;
    endtask

    task automatic prep(input logic [15:0] per);
        wr_ctl(1'b0, 2'd0, 2'd0, 12'd0);
        clr_flags(2'b11);
        wr_p = rd_p;
        wr_per(per);
    endtask

    task automatic t_reset();
        check("R5 reset count", cnt_value, 0);
        check("R5 reset pin", pwm_out, 0);
        check("R8 reset flags", {flag_cmp, flag_rov}, 0);
        check("R8 reset irq", irq, 0);
        check("R9 reset swr", swr_busy, 0);
        check("R6 reset sample", sample_value, 0);
    endtask

    // R2 R4 R5: waveform of one mode over a few output cycles
    task automatic t_mode(input logic [1:0] mode, input int smp, input int per, input int cyc);
        int len;
        int c;
        int exp_out;
        prep(per[15:0]);
        push(smp[15:0]);
        wr_ctl(1'b1, mode, 2'd0, 12'd0);
        len = per + 2;
        check("R5 start sample", sample_value, smp);
        for (int i = 0; i < cyc; i++) begin
            c = i % len;
            if (mode == 2'd0)      exp_out = (c < smp) ? 1 : 0;
            else if (mode == 2'd1) exp_out = (c < smp) ? 0 : 1;
            else                   exp_out = 0;
            check("R2 count", cnt_value, c);
            check("R4 pin", pwm_out, exp_out);
            if (i == len - 1) check("R2 flag before rollover", flag_rov, 0);
            if (i == len)     check("R2 flag at rollover", flag_rov, 1);
            step(1);
        end
    endtask

    task automatic t_prescale();
        prep(16'd3);
        wr_ctl(1'b1, 2'd0, 2'd0, 12'd2);
        for (int i = 0; i < 30; i++) begin
            check("R1 divided count", cnt_value, (i / 3) % 5);
            step(1);
        end
    endtask

    task automatic t_repeat(input logic [1:0] rep);
        int span;
        int idx;
        prep(16'd0);
        push(16'h0100 + rep); push(16'h0200 + rep); push(16'h0300 + rep);
        wr_ctl(1'b1, 2'd0, rep, 12'd0);
        span = 2 << rep;
        for (int i = 0; i < 4 * span; i++) begin
            idx = (i / span > 2) ? 2 : i / span;
            if (i < 3 * span) check("R6 sample in use", sample_value, (idx + 1) * 256 + rep);
            else              check("R7 last sample kept", sample_value, 3 * 256 + rep);
            step(1);
        end
    endtask

    task automatic t_flags();
        prep(16'd4);
        wr_ien(2'b00);
        push(16'd2);
        wr_ctl(1'b1, 2'd0, 2'd0, 12'd0);
        step(7);
        check("R8 compare flag", flag_cmp, 1);
        check("R8 rollover flag", flag_rov, 1);
        check("R8 irq masked", irq, 0);
        wr_ien(2'b01);
        check("R8 irq rollover enabled", irq, 1);
        wr_ctl(1'b0, 2'd0, 2'd0, 12'd0);
        clr_flags(2'b10);
        check("R8 compare cleared", flag_cmp, 0);
        check("R8 rollover kept", flag_rov, 1);
        wr_ien(2'b10);
        check("R8 irq compare only", irq, 0);
        clr_flags(2'b01);
        check("R8 rollover cleared", flag_rov, 0);
        wr_ien(2'b00);
    endtask

    task automatic t_pause();
        prep(16'd200);
        wr_lp(4'b0000);
        wr_ctl(1'b1, 2'd0, 2'd0, 12'd0);
        step(5);
        check("R10 before pause", cnt_value, 5);
        lp_req = 4'b1000;
        step(4);
        check("R10 debug pause holds", cnt_value, 5);
        lp_req = 4'b0000;
        step(3);
        check("R10 resumes", cnt_value, 8);
        wr_lp(4'b1000);
        lp_req = 4'b1000;
        step(4);
        check("R10 debug run bit keeps counting", cnt_value, 13);
        lp_req = 4'b0001;
        step(2);
        check("R10 stop pause holds", cnt_value, 13);
        lp_req = 4'b0000;
        wr_lp(4'b0000);
    endtask

    task automatic t_swr();
        prep(16'd3);
        wr_lp(4'b0001);
        wr_ien(2'b11);
        push(16'd7);
        wr_ctl(1'b1, 2'd0, 2'd0, 12'd0);
        step(6);
        check("R8 irq before reset", irq, 1);
        ctl_wr = 1'b1; ctl_swr = 1'b1;
        step(1);
        ctl_wr = 1'b0; ctl_swr = 1'b0;
        check("R9 swr visible", swr_busy, 1);
        check("R9 pin low", pwm_out, 0);
        check("R9 flags cleared", {flag_cmp, flag_rov}, 0);
        step(1);
        check("R9 swr self cleared", swr_busy, 0);
        check("R9 count cleared", cnt_value, 0);
        check("R9 sample cleared", sample_value, 0);
        lp_req = 4'b0001;
        wr_ctl(1'b1, 2'd0, 2'd0, 12'd0);
        step(1);
        check("R9 stop run bit kept", cnt_value, 1);
        step(1);
        check("R9 period reset to zero", cnt_value, 0);
        check("R9 rollover with zero period", flag_rov, 1);
        check("R9 interrupt enables cleared", irq, 0);
        lp_req = 4'b0000;
        wr_lp(4'b0000);
    endtask

    task automatic t_top_period();
        prep(16'hFFFF);
        wr_ctl(1'b1, 2'd0, 2'd0, 12'd0);
        step(65535);
        check("R3 reaches top count", cnt_value, 16'hFFFF);
        check("R3 no rollover yet", flag_rov, 0);
        step(1);
        check("R3 wraps to zero", cnt_value, 0);
        check("R3 rollover flag", flag_rov, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual %0h expected %0h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_mode(2'd0, 3, 8, 25);
        t_mode(2'd1, 4, 5, 16);
        t_mode(2'd2, 2, 4, 12);
        t_mode(2'd3, 2, 4, 8);
        t_mode(2'd0, 0, 3, 10);
        t_prescale();
        t_repeat(2'd0);
        t_repeat(2'd1);
        t_repeat(2'd2);
        t_repeat(2'd3);
        t_flags();
        t_pause();
        t_swr();
        t_top_period();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule